// File: doc/BRIEF.md
# Coalescing Write Buffer with Read Priority

This block sits on the path from a first-level cache to the next memory level. Stores that leave the cache, whether from write-through traffic or from dirty line evictions, are parked in a small associative buffer instead of going straight down. Each buffer entry covers one 32-byte line and keeps the line data together with one valid bit per byte. A store to a line that is already buffered is folded into that entry. A store to any other line takes a free entry.

Every read miss probes the buffer in the same cycle it is presented. Bytes of the requested word that the buffer holds are returned on a forwarding result. If all bytes of the word are present, the read completes at once and nothing goes downstream. Otherwise the read competes for the single downstream port. There it wins over draining buffered lines, except when every entry is occupied. Buffered lines drain oldest first, one whole line per downstream transfer, with the byte mask attached.

All addresses are word addresses (one word is 4 bytes, a line is 8 words).

Top module: `wbuf_coalesce`

## Requirements
- R1: Out of reset the buffer is empty. `ds_valid` is 0, `wr_ready` is 1 and `rd_fwd_hit` is 0.
- R2: A read miss that is not fully covered by the buffer is placed in the downstream slot when the slot is free. In the cycle it is taken, `rd_ready` is 1. It is then presented with `ds_write`=0 and `ds_addr` equal to the requested word address.
- R3: A write whose line (address bits above the 3 word-select bits) matches a buffered entry merges its enabled bytes into that entry. A write to any other line allocates a new entry. At most 4 entries are ever occupied.
- R4: While a read is probed, `rd_fwd_hit` shows whether its line is buffered. Bit b of `rd_fwd_be` is the byte-valid bit of byte b of the addressed word. Bits 8b+7:8b of `rd_fwd_data` carry that byte, or zero when the byte is not valid.
- R5: A read whose word has all 4 bytes valid in the buffer gets `rd_ready`=1 in the same cycle and causes no downstream read.
- R6: A write is stalled (`wr_ready`=0) when all 4 entries are occupied and its line matches none of them. A merging write is accepted even when the buffer is full.
- R7: When all entries are occupied and the slot is free, the oldest buffered line takes the slot even while a read is waiting.
- R8: A write whose line matches the line currently presented downstream is stalled until that transfer is accepted.
- R9: When the buffer is not full and a read needs the downstream port, the read takes the free slot ahead of buffered lines.
- R10: Buffered lines drain in the order their entries were allocated. `ds_write` is 1 and `ds_addr` is the line-aligned word address. Bit i of `ds_be` is the valid bit of line byte i. Bits 8i+7:8i of `ds_data` carry line byte i.
- R11: While `ds_valid` is 1 and `ds_ready` is 0, the presented request (kind, address, mask, data) does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Upstream write request |
| wr_ready | output | 1 | Write accepted this cycle |
| wr_addr | input | 30 | Word address of the write |
| wr_data | input | 32 | Write data, byte b at bits 8b+7:8b |
| wr_be | input | 4 | Byte enables of the write |
| rd_valid | input | 1 | Read-miss probe request |
| rd_ready | output | 1 | Read completed by forwarding or taken downstream |
| rd_addr | input | 30 | Word address of the read miss |
| rd_fwd_hit | output | 1 | Requested line is present in the buffer |
| rd_fwd_be | output | 4 | Which bytes of the word are forwarded |
| rd_fwd_data | output | 32 | Forwarded bytes, zero where not valid |
| ds_valid | output | 1 | Downstream request valid |
| ds_ready | input | 1 | Downstream accepts the request |
| ds_write | output | 1 | 1 for a line write, 0 for a word read |
| ds_addr | output | 30 | Word address (line-aligned for writes) |
| ds_be | output | 32 | Byte mask of the written line |
| ds_data | output | 256 | Line data of a write |

## Verification
The hardest state to reach is a buffer filled and merged while nothing drains. An idle downstream port grabs the oldest line one cycle after it is written, and that blocks merges into it. The stimulus therefore first sends a read miss and keeps `ds_ready` low, so the read sits in the downstream slot. With the slot held, writes can fill, merge into and overflow all four entries freely. Then `ds_ready` is pulsed one cycle at a time. Each pulse frees the slot, which shows the full-buffer drain, the stall of a write into the line being presented, and read priority once the buffer has room again.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  // kind of request held in the downstream slot
  typedef enum logic {
    KIND_RD = 1'b0,
    KIND_WR = 1'b1
  } ds_kind_e;
endpackage

// File: rtl/wbuf_line_cam.sv
module wbuf_line_cam #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 27,
  parameter int IDX_W = 2
) (
  input  logic [DEPTH-1:0]            vld,
  input  logic [DEPTH-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]            key,
  output logic                        hit,
  output logic [IDX_W-1:0]            idx
);
  // entries never share a line, so at most one compare matches
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld[i] && (tags[i] == key)) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/wbuf_port_arb.sv
module wbuf_port_arb (
  input  logic slot_free,
  input  logic rd_need,
  input  logic buf_full,
  input  logic buf_any,
  output logic launch_rd,
  output logic launch_wr
);
  // reads first, unless every entry is taken
  always_comb begin
    launch_rd = slot_free && rd_need && !buf_full;
    launch_wr = slot_free && buf_any && (!rd_need || buf_full);
  end
endmodule

// File: rtl/wbuf_coalesce.sv
module wbuf_coalesce
  import wbuf_pkg::*;
#(
  parameter int WADDR_W    = 30,
  parameter int WORD_BYTES = 4,
  parameter int LINE_WORDS = 8,
  parameter int DEPTH      = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_valid,
  output logic                               wr_ready,
  input  logic [WADDR_W-1:0]                 wr_addr,
  input  logic [WORD_BYTES*8-1:0]            wr_data,
  input  logic [WORD_BYTES-1:0]              wr_be,
  input  logic                               rd_valid,
  output logic                               rd_ready,
  input  logic [WADDR_W-1:0]                 rd_addr,
  output logic                               rd_fwd_hit,
  output logic [WORD_BYTES-1:0]              rd_fwd_be,
  output logic [WORD_BYTES*8-1:0]            rd_fwd_data,
  output logic                               ds_valid,
  input  logic                               ds_ready,
  output logic                               ds_write,
  output logic [WADDR_W-1:0]                 ds_addr,
  output logic [WORD_BYTES*LINE_WORDS-1:0]   ds_be,
  output logic [WORD_BYTES*LINE_WORDS*8-1:0] ds_data
);
  localparam int LINE_BYTES = WORD_BYTES * LINE_WORDS;
  localparam int WSEL_W     = $clog2(LINE_WORDS);
  localparam int TAG_W      = WADDR_W - WSEL_W;
  localparam int PTR_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W      = $clog2(DEPTH + 1);

  // entry storage
  logic [DEPTH-1:0]                      ent_vld_q, ent_vld_d;
  logic [DEPTH-1:0][TAG_W-1:0]           ent_tag_q, ent_tag_d;
  logic [DEPTH-1:0][LINE_BYTES-1:0][7:0] ent_dat_q, ent_dat_d;
  logic [DEPTH-1:0][LINE_BYTES-1:0]      ent_msk_q, ent_msk_d;
  logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  // downstream slot
  logic               slot_vld_q, slot_vld_d;
  ds_kind_e           slot_kind_q, slot_kind_d;
  logic [WADDR_W-1:0] slot_addr_q, slot_addr_d;

  logic [TAG_W-1:0]  wr_tag, rd_tag;
  logic [WSEL_W-1:0] wr_wsel, rd_wsel;
  logic              wr_hit, rd_hit;
  logic [PTR_W-1:0]  wr_idx, rd_idx, tgt_idx;
  logic buf_full, buf_any, wr_blk_send, wr_fire, wr_alloc;
  logic ds_fire, drain_done, rd_full_hit, rd_need, launch_rd, launch_wr;

  assign wr_tag  = wr_addr[WADDR_W-1:WSEL_W];
  assign wr_wsel = wr_addr[WSEL_W-1:0];
  assign rd_tag  = rd_addr[WADDR_W-1:WSEL_W];
  assign rd_wsel = rd_addr[WSEL_W-1:0];

  wbuf_line_cam #(.DEPTH(DEPTH), .TAG_W(TAG_W), .IDX_W(PTR_W)) u_wr_cam (
    .vld(ent_vld_q), .tags(ent_tag_q), .key(wr_tag), .hit(wr_hit), .idx(wr_idx)
  );
  wbuf_line_cam #(.DEPTH(DEPTH), .TAG_W(TAG_W), .IDX_W(PTR_W)) u_rd_cam (
    .vld(ent_vld_q), .tags(ent_tag_q), .key(rd_tag), .hit(rd_hit), .idx(rd_idx)
  );

  // occupancy and write acceptance
  always_comb begin
    buf_full    = (cnt_q == CNT_W'(DEPTH));
    buf_any     = (cnt_q != '0);
    wr_blk_send = wr_hit && slot_vld_q && (slot_kind_q == KIND_WR) && (wr_idx == head_q);
    wr_ready    = wr_hit ? !wr_blk_send : !buf_full;
    wr_fire     = wr_valid && wr_ready;
    wr_alloc    = wr_fire && !wr_hit;
    tgt_idx     = wr_hit ? wr_idx : tail_q;
    ds_fire     = slot_vld_q && ds_ready;
    drain_done  = ds_fire && (slot_kind_q == KIND_WR);
  end

  // read probe and forwarding
  always_comb begin
    rd_fwd_hit = rd_hit;
    for (int b = 0; b < WORD_BYTES; b++) begin
      rd_fwd_be[b]       = rd_hit && ent_msk_q[rd_idx][int'(rd_wsel)*WORD_BYTES + b];
      rd_fwd_data[8*b+:8] = rd_fwd_be[b] ? ent_dat_q[rd_idx][int'(rd_wsel)*WORD_BYTES + b] : 8'h00;
    end
    rd_full_hit = rd_hit && (&rd_fwd_be);
    rd_need     = rd_valid && !rd_full_hit;
  end

  wbuf_port_arb u_arb (
    .slot_free(!slot_vld_q), .rd_need(rd_need), .buf_full(buf_full), .buf_any(buf_any),
    .launch_rd(launch_rd), .launch_wr(launch_wr)
  );

  assign rd_ready = rd_valid && (rd_full_hit || launch_rd);

  // downstream presentation, payload taken from the head entry
  always_comb begin
    ds_valid = slot_vld_q;
    ds_write = slot_vld_q && (slot_kind_q == KIND_WR);
    ds_addr  = slot_addr_q;
    for (int i = 0; i < LINE_BYTES; i++) begin
      ds_be[i]        = ds_write && ent_msk_q[head_q][i];
      ds_data[8*i+:8] = ds_be[i] ? ent_dat_q[head_q][i] : 8'h00;
    end
  end

  // next state: entries and pointers
  always_comb begin
    ent_vld_d = ent_vld_q;
    ent_tag_d = ent_tag_q;
    ent_dat_d = ent_dat_q;
    ent_msk_d = ent_msk_q;
    if (drain_done) ent_vld_d[head_q] = 1'b0;
    if (wr_fire) begin
      ent_vld_d[tgt_idx] = 1'b1;
      ent_tag_d[tgt_idx] = wr_tag;
      if (wr_alloc) ent_msk_d[tgt_idx] = '0;
      for (int b = 0; b < WORD_BYTES; b++) begin
        if (wr_be[b]) begin
          ent_msk_d[tgt_idx][int'(wr_wsel)*WORD_BYTES + b] = 1'b1;
          ent_dat_d[tgt_idx][int'(wr_wsel)*WORD_BYTES + b] = wr_data[8*b+:8];
        end
      end
    end
    head_d = head_q;
    tail_d = tail_q;
    if (drain_done) head_d = (head_q == PTR_W'(DEPTH-1)) ? '0 : head_q + 1'b1;
    if (wr_alloc)   tail_d = (tail_q == PTR_W'(DEPTH-1)) ? '0 : tail_q + 1'b1;
    cnt_d = cnt_q + CNT_W'(wr_alloc) - CNT_W'(drain_done);
  end

  // next state: downstream slot
  always_comb begin
    slot_vld_d  = slot_vld_q;
    slot_kind_d = slot_kind_q;
    slot_addr_d = slot_addr_q;
    if (ds_fire) begin
      slot_vld_d = 1'b0;
    end else if (launch_rd) begin
      slot_vld_d  = 1'b1;
      slot_kind_d = KIND_RD;
      slot_addr_d = rd_addr;
    end else if (launch_wr) begin
      slot_vld_d  = 1'b1;
      slot_kind_d = KIND_WR;
      slot_addr_d = {ent_tag_q[head_q], {WSEL_W{1'b0}}};
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_vld_q   <= '0;
      head_q      <= '0;
      tail_q      <= '0;
      cnt_q       <= '0;
      slot_vld_q  <= 1'b0;
      slot_kind_q <= KIND_RD;
      slot_addr_q <= '0;
    end else begin
      ent_vld_q   <= ent_vld_d;
      head_q      <= head_d;
      tail_q      <= tail_d;
      cnt_q       <= cnt_d;
      slot_vld_q  <= slot_vld_d;
      slot_kind_q <= slot_kind_d;
      slot_addr_q <= slot_addr_d;
    end
  end

  // payload registers, no reset, enabled by an accepted write
  always_ff @(posedge clk) begin
    if (wr_fire) begin
      ent_tag_q <= ent_tag_d;
      ent_dat_q <= ent_dat_d;
      ent_msk_q <= ent_msk_d;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= CNT_W'(DEPTH)) && ($countones(ent_vld_q) == int'(cnt_q))); // R3

  AST_DS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ds_valid && !ds_ready |=> ds_valid && $stable(ds_write) && $stable(ds_addr)); // R11

  AST_DS_PAYLOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ds_valid && ds_write && !ds_ready |=> $stable(ds_be) && $stable(ds_data)); // R11

  AST_FULL_HIT_NO_DS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_fwd_hit && (&rd_fwd_be) && !ds_valid |=> !(ds_valid && !ds_write)); // R5

  AST_FULL_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full && !ds_valid |=> ds_valid && ds_write); // R7

  AST_NO_MERGE_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
    ds_valid && ds_write && wr_valid && wr_ready
      |-> wr_addr[WADDR_W-1:WSEL_W] != ds_addr[WADDR_W-1:WSEL_W]); // R8
endmodule

// File: tb/wbuf_coalesce_tb_top.sv
module wbuf_coalesce_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_valid, wr_ready;
  logic [29:0]  wr_addr;
  logic [31:0]  wr_data;
  logic [3:0]   wr_be;
  logic         rd_valid, rd_ready;
  logic [29:0]  rd_addr;
  logic         rd_fwd_hit;
  logic [3:0]   rd_fwd_be;
  logic [31:0]  rd_fwd_data;
  logic         ds_valid, ds_ready, ds_write;
  logic [29:0]  ds_addr;
  logic [31:0]  ds_be;
  logic [255:0] ds_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  wbuf_coalesce dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_fwd_hit(rd_fwd_hit), .rd_fwd_be(rd_fwd_be), .rd_fwd_data(rd_fwd_data),
    .ds_valid(ds_valid), .ds_ready(ds_ready), .ds_write(ds_write), .ds_addr(ds_addr),
    .ds_be(ds_be), .ds_data(ds_data)
  );

  task automatic check(input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // write that must be taken in its first cycle
  task automatic push_write(input logic [29:0] a, input logic [31:0] d,
                            input logic [3:0] be, input string req);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_be = be; wr_valid = 1'b1;
    #1;
    check(req, "write accepted", wr_ready, 1'b1);
    @(posedge clk);
    #1 wr_valid = 1'b0;
  endtask

  // write presented for one cycle, expected to stall
  task automatic try_stall(input logic [29:0] a, input string req);
    @(negedge clk);
    wr_addr = a; wr_data = 32'hFFFF_FFFF; wr_be = 4'hF; wr_valid = 1'b1;
    #1;
    check(req, "write stalled", wr_ready, 1'b0);
    wr_valid = 1'b0;
  endtask

  task automatic t_reset;
    rd_addr = 30'h400;
    @(negedge clk); #1;
    check("R1", "ds_valid", ds_valid, 1'b0);
    check("R1", "wr_ready", wr_ready, 1'b1);
    check("R1", "fwd_hit", rd_fwd_hit, 1'b0);
  endtask

  // a read miss parks in the slot; ds_ready stays low to hold it
  task automatic t_read_parks;
    @(negedge clk);
    rd_addr = 30'h2400; rd_valid = 1'b1;
    #1;
    check("R2", "rd_ready on launch", rd_ready, 1'b1);
    @(posedge clk);
    #1 rd_valid = 1'b0;
    @(negedge clk); #1;
    check("R2", "ds read valid", {ds_valid, ds_write}, 2'b10);
    check("R2", "ds read addr", ds_addr, 30'h2400);
  endtask

  task automatic t_fill_and_merge;
    push_write(30'h400, 32'h1122_3344, 4'hF, "R3");
    push_write(30'h401, 32'hAABB_CCDD, 4'h3, "R3");
    push_write(30'h800, 32'h0102_0304, 4'hF, "R3");
    push_write(30'hC02, 32'h5566_7788, 4'hF, "R3");
    // partial forward of the merged word
    @(negedge clk);
    rd_addr = 30'h401; rd_valid = 1'b1;
    #1;
    check("R4", "partial hit", rd_fwd_hit, 1'b1);
    check("R4", "partial be", rd_fwd_be, 4'h3);
    check("R4", "partial data", rd_fwd_data, 32'h0000_CCDD);
    check("R3", "merged read waits", rd_ready, 1'b0);
    rd_addr = 30'h400;
    #1;
    check("R5", "full-word rd_ready", rd_ready, 1'b1);
    check("R4", "full data", rd_fwd_data, 32'h1122_3344);
    rd_valid = 1'b0;
    push_write(30'h1004, 32'hDEAD_BEEF, 4'hF, "R3");
    try_stall(30'h1400, "R6");
    push_write(30'hC03, 32'h99AA_BBCC, 4'hF, "R6");
  endtask

  task automatic t_full_drains;
    @(negedge clk);
    ds_ready = 1'b1; rd_addr = 30'h2801; rd_valid = 1'b1;
    @(negedge clk);
    ds_ready = 1'b0;
    #1;
    check("R7", "read held back when full", rd_ready, 1'b0);
    @(negedge clk); #1;
    check("R7", "drain write valid", {ds_valid, ds_write}, 2'b11);
    check("R10", "oldest line addr", ds_addr, 30'h400);
    check("R10", "line mask", ds_be, 32'h0000_003F);
    check("R10", "line data", ds_data[63:0], 64'h0000_CCDD_1122_3344);
    check("R7", "read still waiting", rd_ready, 1'b0);
    try_stall(30'h402, "R8");
    @(negedge clk); #1;
    check("R11", "held addr", ds_addr, 30'h400);
    check("R11", "held mask", ds_be, 32'h0000_003F);
  endtask

  task automatic t_read_wins;
    ds_ready = 1'b1;
    @(negedge clk);
    ds_ready = 1'b0;
    #1;
    check("R9", "read takes slot", rd_ready, 1'b1);
    @(negedge clk);
    rd_valid = 1'b0;
    #1;
    check("R9", "ds read", {ds_valid, ds_write}, 2'b10);
    check("R2", "ds read addr", ds_addr, 30'h2801);
    ds_ready = 1'b1;
  endtask

  task automatic t_drain_order;
    logic [29:0] seen [0:3];
    int n = 0;
    for (int c = 0; c < 16; c++) begin
      @(negedge clk); #1;
      if (ds_valid && ds_ready && ds_write) begin
        if (n < 4) seen[n] = ds_addr;
        if (ds_addr == 30'hC00) begin
          check("R10", "merged mask", ds_be, 32'h0000_FF00);
          check("R10", "merged data", ds_data[127:64], 64'h99AA_BBCC_5566_7788);
        end
        n++;
      end
    end
    check("R10", "drain count", n, 3);
    check("R10", "drain 1", seen[0], 30'h800);
    check("R10", "drain 2", seen[1], 30'hC00);
    check("R10", "drain 3", seen[2], 30'h1000);
    ds_ready = 1'b0;
    @(negedge clk);
    rd_addr = 30'hC02; rd_valid = 1'b1;
    #1;
    check("R4", "no hit after drain", rd_fwd_hit, 1'b0);
    check("R6", "wr_ready when empty", wr_ready, 1'b1);
    rd_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0; wr_be = '0;
    rd_valid = 1'b0; rd_addr = '0; ds_ready = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_read_parks();
    t_fill_and_merge();
    t_full_drains();
    t_read_wins();
    t_drain_order();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule